// File: doc/BRIEF.md
# Multi-Channel ADC Sampling Sequencer

This block controls an eight-input successive-approximation converter through a small set of registers. Software programs an ordered list of channel numbers and a pre-sample wait time, then starts a run. For each list position the sequencer waits the programmed time and drives the analog mux select with that position's channel. It then raises a conversion request and holds it until the converter answers with a done pulse and a 12-bit result. Each result is masked to the selected resolution, tagged with its channel number and pushed into a 32-entry result queue. Software drains the queue through a data register.

A run is either single-shot, ending after the last list position, or continuous, wrapping back to position 0 until software requests a stop. A stop never abandons a conversion that is already in flight. That result is stored before the sequencer goes idle.

Registers are selected by the 2-bit word address `reg_addr`. Address 0 is control and status, address 1 is the channel list, address 2 is timing and resolution, and address 3 is queue data. Writes take effect at the clock edge where `reg_we` is high. `reg_rdata` follows `reg_addr` without delay. A data read pops the queue at the edge where `reg_re` is high.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, the status word reads 0x0400_0000: queue empty (bit 26), not full (bit 27), count field 0 (bits [25:21]) and sampling busy clear (bit 28). The conversion request is low.
- R2: The channel list register holds eight 3-bit entries, with entry i at bits [3i+2:3i], and a last-index field at bits [26:24]. A single-shot run converts entries 0 through the last index in order, one conversion per entry. The mux select equals the entry's channel during each request, and the block then returns to idle.
- R3: Each queue word reads back at address 3 with the channel at bits [14:12] and the sample at bits [11:0], in conversion order. The status word reports the queue count at bits [25:21], full at bit 27 and empty at bit 26. A pop and a push in the same cycle lose no word.
- R4: The timing register holds a wait count at bits [7:0] and a time-base select at bits [9:8]. Before each request the sequencer waits (count+1)·4^select clock cycles, counted from the edge that starts the run or completes the previous conversion.
- R5: With bit 16 of the timing register set, stored samples keep only their low 10 bits. With it clear, all 12 bits are kept.
- R6: With control bit 1 set, the sequencer wraps from the last index back to entry 0 and keeps converting until a stop is requested.
- R7: Writing control bit 14 stops sampling. During a wait it returns to idle at once with no further request. During a conversion it finishes that conversion, stores its result, then goes idle and clears busy.
- R8: The start bit (control bit 2) starts a run only if the enable bit (control bit 0) is 1 in the same write and the block is idle. Otherwise busy stays clear.
- R9: Reading address 3 while the queue is empty returns the last popped word, and the count stays 0 with empty set.
- R10: When the queue holds 32 words, further results are dropped unless a pop happens in the same cycle. Full reads 1 and the count field reads 0.
- R11: Once raised, the conversion request stays high with a stable mux select until the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the queue at address 3) |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| conv_req | output | 1 | Conversion request to the converter |
| conv_sel | output | 3 | Analog mux channel select |
| conv_done | input | 1 | One-cycle conversion complete pulse |
| conv_result | input | 12 | Raw conversion result, valid with `conv_done` |

## Verification
A queue push from a completing conversion and a queue pop from a data read can land on the same clock edge. A continuous run with a zero wait time keeps pushes frequent while the bench issues back-to-back data reads. The same collision is forced with a full queue. Every word read is compared in order against a bench-side queue that a converter model fills with masked, channel-tagged values. The model also checks the mux select against the programmed list. An occupancy that drifts shows up as a wrong word or a wrong empty reading.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int unsigned SEQ_CHAN_W  = 3;
    localparam int unsigned SEQ_ENTRIES = 8;
    localparam int unsigned SEQ_IDX_W   = 3;
    localparam int unsigned SEQ_LIST_W  = SEQ_CHAN_W * SEQ_ENTRIES;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LIST = 2'd1;
    localparam logic [1:0] ADDR_TIME = 2'd2;
    localparam logic [1:0] ADDR_DATA = 2'd3;

    localparam int unsigned B_ENABLE = 0;
    localparam int unsigned B_CONT   = 1;
    localparam int unsigned B_START  = 2;
    localparam int unsigned B_STOP   = 14;
    localparam int unsigned B_LAST   = 24;
    localparam int unsigned B_DSEL   = 8;
    localparam int unsigned B_NARROW = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CONV = 2'd2
    } seq_state_e;
endpackage

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 15,
    parameter int unsigned CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    localparam int unsigned AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0]    wp;
        logic [AW-1:0]    rp;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] last;
    } fifo_regs_t;

    fifo_regs_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (q.cnt == CNT_W'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign count   = q.cnt;
    assign head    = empty ? q.last : mem[q.rp];

    always_comb begin
        d = q;
        if (push_ok) d.wp = step(q.wp);
        if (pop_ok) begin
            d.rp   = step(q.rp);
            d.last = mem[q.rp];
        end
        d.cnt = q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[q.wp] <= push_data;
    end
endmodule

// File: rtl/adc_seq_delay.sv
module adc_seq_delay #(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned SEL_W     = 2,
    parameter int unsigned PRE_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic [SEL_W-1:0] sel_in,
    output logic             expire
);
    localparam int unsigned PRE_W = (((1 << SEL_W) - 1) * PRE_SHIFT) > 0 ?
                                    (((1 << SEL_W) - 1) * PRE_SHIFT) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PRE_W-1:0] pre;
    } dly_regs_t;

    dly_regs_t q, d;
    logic [PRE_W:0]   period;
    logic [PRE_W:0]   period_m1;
    logic [PRE_W-1:0] pre_load;

    always_comb begin
        period    = (PRE_W + 1)'(1) << (int'(sel_in) * PRE_SHIFT);
        period_m1 = period - (PRE_W + 1)'(1);
        pre_load  = period_m1[PRE_W-1:0];
    end

    assign expire = run && (q.pre == '0) && (q.cnt == '0);

    always_comb begin
        d = q;
        if (load) begin
            d.cnt = cnt_in;
            d.pre = pre_load;
        end else if (run) begin
            if (q.pre != '0) begin
                d.pre = q.pre - 1'b1;
            end else if (q.cnt != '0) begin
                d.cnt = q.cnt - 1'b1;
                d.pre = pre_load;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 32,
    parameter int unsigned SAMPLE_W   = 12,
    parameter int unsigned NARROW_W   = 10,
    parameter int unsigned DLY_W      = 8,
    parameter int unsigned DSEL_W     = 2,
    parameter int unsigned PRE_SHIFT  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic                  reg_re,
    input  logic [1:0]            reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  conv_req,
    output logic [SEQ_CHAN_W-1:0] conv_sel,
    input  logic                  conv_done,
    input  logic [SAMPLE_W-1:0]   conv_result
);
    localparam int unsigned WORD_W = SEQ_CHAN_W + SAMPLE_W;
    localparam int unsigned CNT_W  = $clog2(FIFO_DEPTH) + 1;

    typedef struct packed {
        seq_state_e             st;
        logic [SEQ_IDX_W-1:0]   idx;
        logic [SEQ_CHAN_W-1:0]  sel;
        logic                   stop_pend;
        logic                   en;
        logic                   cont;
        logic [SEQ_LIST_W-1:0]  list;
        logic [SEQ_IDX_W-1:0]   last;
        logic [DLY_W-1:0]       dcnt;
        logic [DSEL_W-1:0]      dsel;
        logic                   narrow;
    } seq_regs_t;

    seq_regs_t q, d;

    logic w_ctrl, w_list, w_time, start_go, stop_req;
    logic tmr_load, tmr_expire, seq_busy;
    logic fifo_push, pop_req, fifo_full, fifo_empty;
    logic [CNT_W-1:0]    fifo_cnt;
    logic [WORD_W-1:0]   fifo_head;
    logic [SAMPLE_W-1:0] keep_mask;
    logic [31:0]         rd_status;
    logic                wr_unused;

    function automatic logic [SEQ_CHAN_W-1:0] entry_of(input logic [SEQ_LIST_W-1:0] lst,
                                                      input logic [SEQ_IDX_W-1:0] i);
        return lst[int'(i) * SEQ_CHAN_W +: SEQ_CHAN_W];
    endfunction

    assign w_ctrl   = reg_we && (reg_addr == ADDR_CTRL);
    assign w_list   = reg_we && (reg_addr == ADDR_LIST);
    assign w_time   = reg_we && (reg_addr == ADDR_TIME);
    assign stop_req = w_ctrl && reg_wdata[B_STOP];
    assign start_go = w_ctrl && reg_wdata[B_START] && reg_wdata[B_ENABLE] && !reg_wdata[B_STOP];
    assign pop_req  = reg_re && (reg_addr == ADDR_DATA);
    assign seq_busy = (q.st != ST_IDLE);
    assign conv_req = (q.st == ST_CONV);
    assign conv_sel = q.sel;
    assign keep_mask = q.narrow ? {{(SAMPLE_W - NARROW_W){1'b0}}, {NARROW_W{1'b1}}} : '1;
    assign wr_unused = ^{reg_wdata, fifo_cnt};

    always_comb begin
        d         = q;
        tmr_load  = 1'b0;
        fifo_push = 1'b0;
        if (w_ctrl) begin
            d.en   = reg_wdata[B_ENABLE];
            d.cont = reg_wdata[B_CONT];
        end
        if (w_list) begin
            d.list = reg_wdata[SEQ_LIST_W-1:0];
            d.last = reg_wdata[B_LAST +: SEQ_IDX_W];
        end
        if (w_time) begin
            d.dcnt   = reg_wdata[DLY_W-1:0];
            d.dsel   = reg_wdata[B_DSEL +: DSEL_W];
            d.narrow = reg_wdata[B_NARROW];
        end
        case (q.st)
            ST_IDLE: begin
                if (start_go) begin
                    d.st        = ST_WAIT;
                    d.idx       = '0;
                    d.sel       = entry_of(q.list, '0);
                    d.stop_pend = 1'b0;
                    tmr_load    = 1'b1;
                end
            end
            ST_WAIT: begin
                if (stop_req)        d.st = ST_IDLE;
                else if (tmr_expire) d.st = ST_CONV;
            end
            ST_CONV: begin
                if (stop_req) d.stop_pend = 1'b1;
                if (conv_done) begin
                    fifo_push = 1'b1;
                    if (q.stop_pend || stop_req) begin
                        d.st        = ST_IDLE;
                        d.stop_pend = 1'b0;
                    end else if (q.idx == q.last) begin
                        if (q.cont) begin
                            d.st     = ST_WAIT;
                            d.idx    = '0;
                            d.sel    = entry_of(q.list, '0);
                            tmr_load = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.st     = ST_WAIT;
                        d.idx    = q.idx + 1'b1;
                        d.sel    = entry_of(q.list, q.idx + 1'b1);
                        tmr_load = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    adc_seq_delay #(
        .CNT_W     (DLY_W),
        .SEL_W     (DSEL_W),
        .PRE_SHIFT (PRE_SHIFT)
    ) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .run    (q.st == ST_WAIT),
        .cnt_in (q.dcnt),
        .sel_in (q.dsel),
        .expire (tmr_expire)
    );

    adc_seq_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (WORD_W),
        .CNT_W (CNT_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data ({q.sel, conv_result & keep_mask}),
        .pop       (pop_req),
        .head      (fifo_head),
        .count     (fifo_cnt),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    always_comb begin
        rd_status          = '0;
        rd_status[28]      = seq_busy;
        rd_status[27]      = fifo_full;
        rd_status[26]      = fifo_empty;
        rd_status[25:21]   = 5'(fifo_cnt);
        rd_status[B_CONT]  = q.cont;
        rd_status[B_ENABLE] = q.en;
        case (reg_addr)
            ADDR_CTRL: reg_rdata = rd_status;
            ADDR_LIST: reg_rdata = {5'b0, q.last, q.list};
            ADDR_TIME: reg_rdata = 32'({q.narrow, 6'b0, q.dsel, q.dcnt});
            default:   reg_rdata = 32'(fifo_head);
        endcase
    end
endmodule

// File: rtl/adc_seq_sva.sv
module adc_seq_sva #(
    parameter int unsigned CNT_W = 6,
    parameter int unsigned DEPTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_req,
    input logic             conv_done,
    input logic [2:0]       conv_sel,
    input logic             busy,
    input logic             fifo_push,
    input logic             fifo_pop,
    input logic             fifo_full,
    input logic             fifo_empty,
    input logic [CNT_W-1:0] fifo_cnt
);
    // R11: request held until done
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && !conv_done |=> conv_req);

    // R11: mux select steady while waiting for the converter
    p_sel_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && !conv_done |=> $stable(conv_sel));

    // R7: no request while idle
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !conv_req);

    // R3: full and empty never together, count bounded
    p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    // R10: push into a full queue without a pop changes nothing
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full && fifo_push && !fifo_pop |=> fifo_full && $stable(fifo_cnt));

    // R9: pop of an empty queue leaves it empty
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty && fifo_pop && !fifo_push |=> fifo_empty);
endmodule

bind adc_seq_top adc_seq_sva #(
    .CNT_W ($clog2(FIFO_DEPTH) + 1),
    .DEPTH (FIFO_DEPTH)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_req   (conv_req),
    .conv_done  (conv_done),
    .conv_sel   (conv_sel),
    .busy       (seq_busy),
    .fifo_push  (fifo_push),
    .fifo_pop   (pop_req),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .fifo_cnt   (fifo_cnt)
);

// File: tb/adc_seq_top_tb.sv
`timescale 1ns/1ps
module adc_seq_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        conv_req;
    logic [2:0]  conv_sel;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;

    int errors = 0, checks = 0;
    logic [14:0] exp_q [$];
    logic [31:0] last_word = '0;

    logic [23:0] m_list = '0;
    logic [2:0]  m_last = '0, m_idx = '0;
    logic        m_narrow = 1'b0;
    int          lat_cfg = 2, done_cnt = 0;
    logic        force_en = 1'b0;
    logic [11:0] force_val = '0;

    always #2 clk = ~clk;

    adc_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .conv_req(conv_req), .conv_sel(conv_sel), .conv_done(conv_done),
        .conv_result(conv_result)
    );

    function automatic logic [11:0] keep(input logic [11:0] v, input logic nar);
        return nar ? {2'b0, v[9:0]} : v;
    endfunction

    function automatic int wait_cycles(input int cnt, input int sel);
        return (cnt + 1) * (1 << (2 * sel));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // converter model
    initial begin
        int lat = 0;
        logic pend = 1'b0;
        logic [14:0] pw;
        logic [11:0] v;
        logic [2:0] ec;
        forever begin
            @(negedge clk);
            if (pend) begin
                if (exp_q.size() < 32) exp_q.push_back(pw);
                pend = 1'b0;
            end
            conv_done = 1'b0;
            if (conv_req) begin
                lat++;
                if (lat >= lat_cfg) begin
                    lat = 0;
                    v = force_en ? force_val : 12'($urandom);
                    ec = m_list[int'(m_idx) * 3 +: 3];
                    chk("R2 mux select", 32'(conv_sel), 32'(ec));
                    conv_result = v;
                    conv_done = 1'b1;
                    pw = {ec, keep(v, m_narrow)};
                    pend = 1'b1;
                    done_cnt++;
                    m_idx = (m_idx == m_last) ? 3'd0 : m_idx + 3'd1;
                end
            end else begin
                lat = 0;
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] dat);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = dat;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] dat);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1 dat = reg_rdata;
        @(posedge clk);
        #1 reg_re = 1'b0;
    endtask

    task automatic pop_check(input string req);
        logic [31:0] dat, e;
        rd(2'd3, dat);
        if (exp_q.size() > 0) e = 32'(exp_q.pop_front());
        else                  e = last_word;
        chk(req, dat, e);
        last_word = e;
    endtask

    task automatic cfg(input logic [23:0] lst, input logic [2:0] lastix,
                       input logic [7:0] cnt, input logic [1:0] sel, input logic nar);
        wr(2'd1, {5'b0, lastix, lst});
        wr(2'd2, 32'({nar, 6'b0, sel, cnt}));
        m_list = lst; m_last = lastix; m_narrow = nar;
    endtask

    task automatic start(input logic cont);
        m_idx = 3'd0;
        wr(2'd0, 32'h5 | (32'(cont) << 1));
    endtask

    task automatic stop(input logic cont);
        wr(2'd0, 32'h4001 | (32'(cont) << 1));
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(2'd0, s);
            if (!s[28]) break;
        end
    endtask

    task automatic drain(input string req);
        logic [31:0] s;
        rd(2'd0, s);
        for (int i = 0; i < 40 && !s[26]; i++) begin
            pop_check(req);
            rd(2'd0, s);
        end
    endtask

    task automatic wait_done(input int target);
        for (int i = 0; i < 5000 && done_cnt < target; i++) @(negedge clk);
    endtask

    task automatic measure(input int exp_n, input string req);
        int n = 0;
        while (!conv_req && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(req, 32'(n), 32'(exp_n));
    endtask

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] s, dat;
        int base;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, s);
        chk("R1 status", s, 32'h0400_0000);
        chk("R1 request", 32'(conv_req), 32'd0);

        // R2 R4: four-entry single shot
        cfg({15'd0, 3'd0, 3'd7, 3'd2, 3'd5}, 3'd3, 8'd2, 2'd0, 1'b0);
        base = done_cnt;
        start(1'b0);
        measure(wait_cycles(2, 0), "R4 wait sel0");
        wait_idle();
        chk("R2 conversions", 32'(done_cnt - base), 32'd4);
        rd(2'd0, s);
        chk("R3 count field", 32'(s[25:21]), 32'd4);
        drain("R3 word order");

        // R4 other time bases
        cfg(24'd3, 3'd0, 8'd1, 2'd1, 1'b0);
        start(1'b0);
        measure(wait_cycles(1, 1), "R4 wait sel1");
        wait_idle(); drain("R4 data");
        cfg(24'd4, 3'd0, 8'd0, 2'd2, 1'b0);
        start(1'b0);
        measure(wait_cycles(0, 2), "R4 wait sel2");
        wait_idle(); drain("R4 data");

        // R5 resolution mask
        force_en = 1'b1; force_val = 12'hABC;
        cfg(24'd6, 3'd0, 8'd0, 2'd0, 1'b1);
        start(1'b0); wait_idle();
        rd(2'd3, dat);
        chk("R5 narrow", dat, 32'h62BC);
        void'(exp_q.pop_front()); last_word = dat;
        cfg(24'd6, 3'd0, 8'd0, 2'd0, 1'b0);
        start(1'b0); wait_idle();
        rd(2'd3, dat);
        chk("R5 wide", dat, 32'h6ABC);
        void'(exp_q.pop_front()); last_word = dat;
        force_en = 1'b0;

        // R9 empty read
        rd(2'd3, dat);
        chk("R9 empty read", dat, last_word);
        rd(2'd0, s);
        chk("R9 count/empty", 32'(s[26:21]), 32'h20);

        // R6 continuous wrap
        cfg({18'd0, 3'd3, 3'd1}, 3'd1, 8'd0, 2'd0, 1'b0);
        base = done_cnt;
        start(1'b1);
        wait_done(base + 7);
        stop(1'b1);
        wait_idle();
        chk("R6 wrapped", 32'(done_cnt - base >= 7), 32'd1);
        drain("R6 sequence");

        // R7 stop during conversion
        lat_cfg = 30;
        cfg({18'd0, 3'd2, 3'd1}, 3'd2, 8'd0, 2'd0, 1'b0);
        base = done_cnt;
        start(1'b0);
        measure(1, "R4 wait min");
        stop(1'b0);
        wait_idle();
        chk("R7 finished one", 32'(done_cnt - base), 32'd1);
        begin
            int hits = 0;
            repeat (60) begin @(negedge clk); if (conv_req) hits++; end
            chk("R7 no request after stop", 32'(hits), 32'd0);
        end
        drain("R7 result");
        lat_cfg = 2;

        // R7 stop during wait
        cfg(24'd5, 3'd0, 8'd200, 2'd0, 1'b0);
        base = done_cnt;
        start(1'b0);
        repeat (20) @(negedge clk);
        stop(1'b0);
        rd(2'd0, s);
        chk("R7 busy cleared", 32'(s[28]), 32'd0);
        begin
            int hits = 0;
            repeat (250) begin @(negedge clk); if (conv_req) hits++; end
            chk("R7 wait aborted", 32'(hits), 32'd0);
        end

        // R8 start without enable
        wr(2'd0, 32'h4);
        repeat (5) @(negedge clk);
        rd(2'd0, s);
        chk("R8 busy", 32'(s[28]), 32'd0);
        chk("R8 request", 32'(conv_req), 32'd0);

        // R10 full queue
        lat_cfg = 1;
        cfg(24'($urandom), 3'd7, 8'd0, 2'd0, 1'b0);
        base = done_cnt;
        start(1'b1);
        wait_done(base + 40);
        stop(1'b1);
        wait_idle();
        rd(2'd0, s);
        chk("R10 full/empty/count", 32'(s[27:21]), 32'h40);
        for (int i = 0; i < 32; i++) pop_check("R10 kept words");
        rd(2'd0, s);
        chk("R10 drained", 32'(s[26]), 32'd1);

        // R3 push and pop colliding
        lat_cfg = 2;
        cfg(24'($urandom), 3'd5, 8'd0, 2'd0, 1'b0);
        start(1'b1);
        for (int i = 0; i < 50; i++) pop_check("R3 push/pop same cycle");
        stop(1'b1);
        wait_idle();
        drain("R3 after collision");

        // random single-shot runs
        for (int t = 0; t < 12; t++) begin
            logic [2:0] lx;
            lx = 3'($urandom);
            lat_cfg = 1 + int'($urandom % 4);
            cfg(24'($urandom), lx, 8'($urandom % 4), 2'($urandom % 2), 1'($urandom));
            base = done_cnt;
            start(1'b0);
            for (int i = 0; i < 600; i++) begin
                rd(2'd0, s);
                if (!s[28]) break;
                if ($urandom % 2 == 0) pop_check("R2 random run");
            end
            chk("R2 random count", 32'(done_cnt - base), 32'(int'(lx) + 1));
            drain("R2 random data");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule